// File: doc/BRIEF.md
# Peripheral Bus Access Protection Unit

This unit sits on the path from a bus master to a set of up to 64 peripheral register regions. Each access presents a peripheral ID, a privilege bit and a bit telling whether the access arrives through the secure address alias. Two per-peripheral attribute bitmaps decide whether the access may proceed. One bitmap marks peripherals as privileged-only. The other marks peripherals as secure. An access that fails either test is blocked combinationally: the peripheral-side request and write strobe stay low, and the master sees all-zero read data.

Every blocked access sets a sticky flag and stores the ID of the peripheral it targeted. Privilege faults and alias-mismatch faults have separate flags. Software reaches enable, attributes, flags, interrupt enables and fault status through a small single-cycle register port. Writes take effect at the clock edge and reads are combinational. A single interrupt output is high while any flag that is enabled is pending.

Top module: `periph_guard`

## Requirements
- R1: When the unit is enabled and an unprivileged access (acc_priv_i=0) targets a peripheral whose privilege attribute bit is 1, per_req_o and per_we_o stay 0 in that cycle.
- R2: A blocked access returns acc_rdata_o = 0. A passed access returns per_rdata_i unchanged, with per_addr_o and per_wdata_o equal to the master's values.
- R3: ID n below 32 selects bit n of attribute word 0. ID 32+n selects bit n of attribute word 1. The privilege words are at cfg addresses 1 and 2, and the security words are at cfg addresses 3 and 4.
- R4: A privilege fault sets flag bit 0 (cfg address 5) and loads the peripheral ID into the fault-ID register (cfg address 10). Both are visible one cycle after the access.
- R5: When enabled, an access whose alias bit differs from the peripheral's security attribute bit is blocked. It sets flag bit 1 and loads the fault-ID register.
- R6: irq_o is 1 exactly when (flags AND enables) is non-zero. The enables are at cfg address 8, and the pending-and-enabled value reads at cfg address 9. Reading never clears a flag. A flag that is already pending raises irq_o in the cycle after its enable bit is written.
- R7: Flags are sticky. Writing 1s to cfg address 7 clears them. Writing 1s to cfg address 6 sets them. A hardware fault in the same cycle as a clear of the same bit leaves the bit set.
- R8: After reset, control bit 0 (enable, cfg address 0) is 1. The attribute words, flags, enables and fault ID are all 0.
- R9: With control bit 0 cleared, every access is forwarded unchanged and no flag is set.
- R10: The fault-ID register always holds the ID of the most recent fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_req_i | input | 1 | Master access request |
| acc_we_i | input | 1 | Master write strobe |
| acc_id_i | input | 6 | Target peripheral ID |
| acc_priv_i | input | 1 | Access is privileged |
| acc_alias_sec_i | input | 1 | Access uses the secure address alias |
| acc_addr_i | input | ADDR_W | Master address |
| acc_wdata_i | input | DATA_W | Master write data |
| acc_rdata_o | output | DATA_W | Read data to master, zero when blocked |
| per_req_o | output | 1 | Request to peripheral |
| per_we_o | output | 1 | Write strobe to peripheral |
| per_addr_o | output | ADDR_W | Address to peripheral |
| per_wdata_o | output | DATA_W | Write data to peripheral |
| per_rdata_i | input | DATA_W | Read data from peripheral |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets several corner cases, and each has a visible symptom when the design gets it wrong:
- Peripherals on either side of the ID-32 word boundary: a wrong word or bit select protects the wrong neighbour.
- A hardware fault that lands in the same cycle as a software clear: a design where clear wins would silently lose the event.
- A flag that is already pending when its enable is written: a design that only reacts to new flags would never raise irq_o.
- Two faults in a row: a design that latches the first fault's ID would report a stale value.
- Disabled mode: with enable cleared, every access must pass and no flag may appear.

Randomized accesses and attribute writes are compared against a bench model of both bitmaps.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int unsigned FLAG_W   = 2;
  localparam int unsigned FLG_PRIV = 0;
  localparam int unsigned FLG_SEC  = 1;

  localparam logic [3:0] ADR_CTRL  = 4'd0;
  localparam logic [3:0] ADR_PRIV0 = 4'd1;
  localparam logic [3:0] ADR_SEC0  = 4'd3;
  localparam logic [3:0] ADR_FLAGS = 4'd5;
  localparam logic [3:0] ADR_FSET  = 4'd6;
  localparam logic [3:0] ADR_FCLR  = 4'd7;
  localparam logic [3:0] ADR_IEN   = 4'd8;
  localparam logic [3:0] ADR_PEND  = 4'd9;
  localparam logic [3:0] ADR_FID   = 4'd10;
endpackage

// File: rtl/pg_attr_check.sv
module pg_attr_check #(
  parameter int unsigned ID_W  = 6,
  parameter int unsigned MAP_W = 64
) (
  input  logic             en_i,
  input  logic             req_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic             priv_i,
  input  logic             alias_sec_i,
  input  logic [MAP_W-1:0] priv_map_i,
  input  logic [MAP_W-1:0] sec_map_i,
  output logic             priv_fault_o,
  output logic             sec_fault_o,
  output logic             deny_o
);
  logic priv_only, is_secure;

  assign priv_only    = priv_map_i[id_i];
  assign is_secure    = sec_map_i[id_i];
  assign priv_fault_o = en_i & req_i & priv_only & ~priv_i;
  assign sec_fault_o  = en_i & req_i & (is_secure ^ alias_sec_i);
  assign deny_o       = priv_fault_o | sec_fault_o;
endmodule

// File: rtl/pg_regs.sv
module pg_regs
  import pg_pkg::*;
#(
  parameter int unsigned NW   = 2,
  parameter int unsigned ID_W = 6,
  localparam int unsigned MAP_W = NW * 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [3:0]        cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic [FLAG_W-1:0] hw_flag_i,
  input  logic              hw_fault_i,
  input  logic [ID_W-1:0]   hw_fid_i,
  output logic              en_o,
  output logic [MAP_W-1:0]  priv_map_o,
  output logic [MAP_W-1:0]  sec_map_o,
  output logic              irq_o
);
  logic              en_q;
  logic [FLAG_W-1:0] flags_q, ien_q, set_v, clr_v, pend;
  logic [ID_W-1:0]   fid_q;

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic [31:0] priv_q, sec_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        priv_q <= '0;
        sec_q  <= '0;
      end else if (cfg_we_i) begin
        if (cfg_addr_i == ADR_PRIV0 + 4'(w)) priv_q <= cfg_wdata_i;
        if (cfg_addr_i == ADR_SEC0 + 4'(w))  sec_q  <= cfg_wdata_i;
      end
    end
    assign priv_map_o[w*32 +: 32] = priv_q;
    assign sec_map_o[w*32 +: 32]  = sec_q;
  end

  assign set_v = (cfg_we_i && cfg_addr_i == ADR_FSET) ? cfg_wdata_i[FLAG_W-1:0] : '0;
  assign clr_v = (cfg_we_i && cfg_addr_i == ADR_FCLR) ? cfg_wdata_i[FLAG_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b1;
      ien_q   <= '0;
      flags_q <= '0;
      fid_q   <= '0;
    end else begin
      if (cfg_we_i && cfg_addr_i == ADR_CTRL) en_q  <= cfg_wdata_i[0];
      if (cfg_we_i && cfg_addr_i == ADR_IEN)  ien_q <= cfg_wdata_i[FLAG_W-1:0];
      // set sources win over clear
      flags_q <= (flags_q & ~clr_v) | set_v | hw_flag_i;
      if (hw_fault_i) fid_q <= hw_fid_i;
    end
  end

  assign pend  = flags_q & ien_q;
  assign irq_o = |pend;
  assign en_o  = en_q;

  always_comb begin
    cfg_rdata_o = '0;
    case (cfg_addr_i)
      ADR_CTRL:  cfg_rdata_o = {31'b0, en_q};
      ADR_FLAGS: cfg_rdata_o = {{(32-FLAG_W){1'b0}}, flags_q};
      ADR_IEN:   cfg_rdata_o = {{(32-FLAG_W){1'b0}}, ien_q};
      ADR_PEND:  cfg_rdata_o = {{(32-FLAG_W){1'b0}}, pend};
      ADR_FID:   cfg_rdata_o = {{(32-ID_W){1'b0}}, fid_q};
      default:   ;
    endcase
    for (int w = 0; w < NW; w++) begin
      if (cfg_addr_i == ADR_PRIV0 + 4'(w)) cfg_rdata_o = priv_map_o[w*32 +: 32];
      if (cfg_addr_i == ADR_SEC0 + 4'(w))  cfg_rdata_o = sec_map_o[w*32 +: 32];
    end
  end

  assert_priv_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_flag_i[FLG_PRIV] |=> flags_q[FLG_PRIV]);
  assert_sec_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_flag_i[FLG_SEC] |=> flags_q[FLG_SEC]);
  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q[FLG_PRIV] && !(cfg_we_i && cfg_addr_i == ADR_FCLR && cfg_wdata_i[FLG_PRIV]))
      |=> flags_q[FLG_PRIV]);
  assert_late_enable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q[FLG_PRIV] && $rose(ien_q[FLG_PRIV])) |-> irq_o);
  assert_fid_recent_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_fault_i |=> fid_q == $past(hw_fid_i));
endmodule

// File: rtl/periph_guard.sv
module periph_guard
  import pg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned N_PERIPH = 64,
  localparam int unsigned ID_W    = $clog2(N_PERIPH),
  localparam int unsigned NW      = (N_PERIPH + 31) / 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_req_i,
  input  logic              acc_we_i,
  input  logic [ID_W-1:0]   acc_id_i,
  input  logic              acc_priv_i,
  input  logic              acc_alias_sec_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic [DATA_W-1:0] acc_rdata_o,
  output logic              per_req_o,
  output logic              per_we_o,
  output logic [ADDR_W-1:0] per_addr_o,
  output logic [DATA_W-1:0] per_wdata_o,
  input  logic [DATA_W-1:0] per_rdata_i,
  input  logic              cfg_we_i,
  input  logic [3:0]        cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned MAP_W = NW * 32;

  logic             en, priv_fault, sec_fault, deny;
  logic [MAP_W-1:0] priv_map, sec_map;

  pg_attr_check #(.ID_W(ID_W), .MAP_W(MAP_W)) u_check (
    .en_i(en), .req_i(acc_req_i), .id_i(acc_id_i), .priv_i(acc_priv_i),
    .alias_sec_i(acc_alias_sec_i), .priv_map_i(priv_map), .sec_map_i(sec_map),
    .priv_fault_o(priv_fault), .sec_fault_o(sec_fault), .deny_o(deny)
  );

  pg_regs #(.NW(NW), .ID_W(ID_W)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .hw_flag_i({sec_fault, priv_fault}), .hw_fault_i(deny), .hw_fid_i(acc_id_i),
    .en_o(en), .priv_map_o(priv_map), .sec_map_o(sec_map), .irq_o
  );

  assign per_req_o   = acc_req_i & ~deny;
  assign per_we_o    = acc_we_i & ~deny;
  assign per_addr_o  = acc_addr_i;
  assign per_wdata_o = acc_wdata_i;
  assign acc_rdata_o = deny ? '0 : per_rdata_i;

  assert_priv_block_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_req_i && en && priv_map[acc_id_i] && !acc_priv_i) |-> (!per_req_o && !per_we_o));
  assert_zero_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_req_i && !per_req_o) |-> acc_rdata_o == '0);
  assert_disabled_fwd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (per_req_o == acc_req_i && per_we_o == acc_we_i));
endmodule

// File: tb/periph_guard_bench.sv
`timescale 1ns/1ps
module periph_guard_bench;
  logic        clk = 0, rst_ni = 0;
  logic        acc_req_i = 0, acc_we_i = 0, acc_priv_i = 0, acc_alias_sec_i = 0;
  logic [5:0]  acc_id_i = 0;
  logic [11:0] acc_addr_i = 0;
  logic [31:0] acc_wdata_i = 0, per_rdata_i = 0, cfg_wdata_i = 0;
  logic        cfg_we_i = 0;
  logic [3:0]  cfg_addr_i = 0;
  logic [31:0] acc_rdata_o, per_wdata_o, cfg_rdata_o;
  logic [11:0] per_addr_o;
  logic        per_req_o, per_we_o, irq_o;

  int total = 0, bad = 0;
  logic        en_m;
  logic [63:0] priv_m, sec_m;
  logic [1:0]  flags_m, ien_m;
  logic [5:0]  fid_m;

  always #4 clk = ~clk;

  periph_guard u_periph_guard (
    .clk_i(clk), .rst_ni, .acc_req_i, .acc_we_i, .acc_id_i, .acc_priv_i,
    .acc_alias_sec_i, .acc_addr_i, .acc_wdata_i, .acc_rdata_o, .per_req_o,
    .per_we_o, .per_addr_o, .per_wdata_o, .per_rdata_i, .cfg_we_i, .cfg_addr_i,
    .cfg_wdata_i, .cfg_rdata_o, .irq_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_pf(logic [5:0] id, logic pv);
    return en_m && priv_m[id] && !pv;
  endfunction
  function automatic logic exp_sf(logic [5:0] id, logic al);
    return en_m && (sec_m[id] != al);
  endfunction

  // one cycle: optional access plus optional register write
  task automatic step(logic req, logic [5:0] id, logic pv, logic al, logic we,
                      logic cwe, logic [3:0] ca, logic [31:0] cd, string tag);
    logic pf, sf, dn;
    @(negedge clk);
    acc_req_i = req; acc_id_i = id; acc_priv_i = pv; acc_alias_sec_i = al;
    acc_we_i = we; acc_addr_i = 12'($urandom); acc_wdata_i = $urandom;
    per_rdata_i = $urandom;
    cfg_we_i = cwe; cfg_addr_i = ca; cfg_wdata_i = cd;
    #1;
    pf = req && exp_pf(id, pv);
    sf = req && exp_sf(id, al);
    dn = pf || sf;
    if (req) begin
      chk({tag, " R1 req"}, 32'(per_req_o), 32'(!dn));
      chk({tag, " R1 we"}, 32'(per_we_o), 32'(we && !dn));
      chk({tag, " R2 rdata"}, acc_rdata_o, dn ? 32'h0 : per_rdata_i);
      if (!dn) begin
        chk({tag, " R2 addr"}, 32'(per_addr_o), 32'(acc_addr_i));
        chk({tag, " R2 wdata"}, per_wdata_o, acc_wdata_i);
      end
    end
    @(posedge clk);
    if (cwe) begin
      case (ca)
        4'd0: en_m = cd[0];
        4'd1: priv_m[31:0] = cd;
        4'd2: priv_m[63:32] = cd;
        4'd3: sec_m[31:0] = cd;
        4'd4: sec_m[63:32] = cd;
        4'd8: ien_m = cd[1:0];
        default: ;
      endcase
    end
    flags_m = (flags_m & ~((cwe && ca == 4'd7) ? cd[1:0] : 2'b0))
            | ((cwe && ca == 4'd6) ? cd[1:0] : 2'b0) | {sf, pf};
    if (dn) fid_m = id;
    @(negedge clk);
    acc_req_i = 0; acc_we_i = 0; cfg_we_i = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    step(0, 0, 0, 0, 0, 1, a, d, "cfg");
  endtask
  task automatic acc(logic [5:0] id, logic pv, logic al, string tag);
    step(1, id, pv, al, 1'($urandom), 0, 0, 0, tag);
  endtask

  task automatic rd_chk(logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    cfg_we_i = 0; cfg_addr_i = a; #1;
    chk(tag, cfg_rdata_o, exp);
  endtask

  task automatic state_chk(string tag);
    rd_chk(4'd5, {30'b0, flags_m}, {tag, " R4/R5/R7 flags"});
    rd_chk(4'd10, {26'b0, fid_m}, {tag, " R10 fid"});
    rd_chk(4'd9, {30'b0, flags_m & ien_m}, {tag, " R6 pend"});
    chk({tag, " R6 irq"}, 32'(irq_o), 32'(|(flags_m & ien_m)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    en_m = 1; priv_m = 0; sec_m = 0; flags_m = 0; ien_m = 0; fid_m = 0;
    repeat (3) @(posedge clk);
    rst_ni = 1;
    // R8 reset values
    rd_chk(4'd0, 32'd1, "R8 ctrl");
    rd_chk(4'd1, 0, "R8 priv0");
    rd_chk(4'd2, 0, "R8 priv1");
    rd_chk(4'd3, 0, "R8 sec0");
    rd_chk(4'd4, 0, "R8 sec1");
    rd_chk(4'd8, 0, "R8 ien");
    rd_chk(4'd5, 0, "R8 flags");
    rd_chk(4'd10, 0, "R8 fid");
    chk("R8 irq", 32'(irq_o), 0);

    acc(6'd5, 0, 0, "R2 pass");
    // R3: id 35 is bit 3 of word 1; id 3 must stay open
    wr(4'd2, 32'h8);
    rd_chk(4'd2, 32'h8, "R3 priv1 readback");
    acc(6'd3, 0, 0, "R3 id3 open");
    state_chk("R3 no fault");
    acc(6'd35, 0, 0, "R1 id35 blocked");
    state_chk("R4 after priv fault");
    acc(6'd35, 1, 0, "R1 priv pass");
    // R6: pending before enable, reads do not clear
    state_chk("R6 reread");
    wr(4'd8, 32'h1);
    chk("R6 late enable irq", 32'(irq_o), 1);
    state_chk("R6 enabled");
    // R7 clear, then set via software
    wr(4'd7, 32'h1);
    state_chk("R7 cleared");
    wr(4'd6, 32'h2);
    state_chk("R7 sw set");
    wr(4'd7, 32'h3);
    // R5 security alias mismatch, both directions
    wr(4'd3, 32'h80);
    acc(6'd7, 0, 0, "R5 secure via ns alias");
    state_chk("R5 flag");
    acc(6'd7, 0, 1, "R5 secure via s alias");
    acc(6'd8, 0, 1, "R5 ns via s alias");
    rd_chk(4'd10, 32'd8, "R5 fid 8");
    // R10 most recent
    acc(6'd35, 0, 0, "R10 first");
    acc(6'd7, 0, 0, "R10 second");
    rd_chk(4'd10, 32'd7, "R10 latest fid");
    // R7 fault beats same-cycle clear
    step(1, 6'd35, 0, 0, 0, 1, 4'd7, 32'h3, "R7 set wins");
    rd_chk(4'd5, 32'h1, "R7 hw set beats clear");
    wr(4'd7, 32'h3);
    // R9 disabled
    wr(4'd0, 32'h0);
    acc(6'd35, 0, 1, "R9 disabled pass");
    rd_chk(4'd5, 32'h0, "R9 no flag");
    wr(4'd0, 32'h1);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [5:0] id;
      op = int'($urandom % 10);
      id = 6'($urandom);
      case (op)
        0: wr(4'd1 + 4'($urandom % 4), $urandom & $urandom);
        1: wr(4'd8, 32'($urandom % 4));
        2: wr(4'd7, 32'($urandom % 4));
        3: wr(4'd6, 32'($urandom % 4));
        4: wr(4'd0, 32'($urandom % 8 != 0));
        default: acc(id, 1'($urandom), ($urandom % 4 == 0) ? !sec_m[id] : sec_m[id], "rnd");
      endcase
      if (i % 8 == 0) state_chk("rnd");
    end
    state_chk("final");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule